// File: doc/BRIEF.md
# Quad Wiper Register Two-Wire Slave

This block is the serial control front end of a four-channel digital potentiometer. It holds four 8-bit volatile wiper registers and exposes them to a host over a two-wire I2C bus, on which it acts only as a slave. Raw SCL and SDA arrive asynchronously. Each line passes through a two-flop synchronizer and a pulse-rejection filter. The filtered lines feed a bus-condition detector and a byte-level protocol engine.

A host selects the device with a 7-bit identification whose upper four bits are fixed at binary 0101 and whose lower three bits are read from strap pins. It then sends an address byte that picks one of the four wipers. A write stores exactly one data byte and then ignores the bus until the next START or STOP. A read begins with a repeated START after the address byte. The slave then streams wiper values for as long as the host acknowledges, and the pointer wraps from the last wiper back to the first. The block drives SDA only by asserting an open-drain pull-down enable. The four wiper values leave the block as one flat vector that feeds the analog ladder.

Top module: `quad_wiper_i2c`

## Requirements
- R1: While reset is asserted and after it is released, all four wipers read 80h and the SDA pull-down enable is 0.
- R2: The identification byte is bits [7:4] = 0101, bits [3:1] = strap_i[2:0], and bit [0] = direction (0 = write, 1 = read). Every byte is shifted MSB first. A matching byte is acknowledged by pulling SDA low during the ninth clock.
- R3: An identification byte that does not match is not acknowledged. No byte after it is acknowledged until the next START.
- R4: An address byte from 00h to 03h selects wiper 0 to 3 and is acknowledged. A larger value is not acknowledged, and the write data byte that follows is also not acknowledged and changes no wiper.
- R5: In a write, the single data byte after the address byte is stored into the selected wiper and acknowledged. Any further data byte in the same transfer is not acknowledged and changes no wiper. At most one wiper changes in any clock cycle.
- R6: After a repeated START and a read identification byte, the slave sends the selected wiper, then each following wiper index in turn, wrapping from index 3 to index 0. It sends a new byte each time the host acknowledges.
- R7: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START.
- R8: A STOP or START in the middle of a byte ends that transfer without changing any wiper. A new transfer after such a START works normally.
- R9: The SDA pull-down enable and the wiper outputs change only while the filtered SCL is low.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks has no effect on the transfer.
- R11: Before the first START, clocked bus activity is ignored: nothing is acknowledged and no wiper changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line level |
| sda_i | input | 1 | Raw serial data line level |
| strap_i | input | STRAP_W (3) | Strap levels that form the low identification bits |
| sda_oe_o | output | 1 | 1 = pull SDA low (open drain) |
| wiper_o | output | NUM_WIPERS*WIPER_W (32) | Wiper values, wiper k in bits [8k+7:8k] |

## Verification
Writes are swept over every wiper index with all-zero, all-one and two index-dependent data patterns. This separates a wrong register select from a wrong bit order, and it shows a stuck or shared bit. Reads start at each of the four indices and run six bytes, so every wrap position and the pointer increment are compared against a model of the values written. Near-miss identification bytes flip one prefix bit or one strap bit at a time, and out-of-range addresses, extra data bytes, mid-byte STOP and START, unstarted clocking and sub-threshold glitches on both lines each show a distinct fault in acknowledge handling, abort handling or input filtering.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

   // protocol engine states
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,   // released, waits for START
      ST_ID    = 3'd1,   // shifting in identification byte
      ST_REG   = 3'd2,   // shifting in address byte
      ST_WDATA = 3'd3,   // shifting in write data byte
      ST_ACK   = 3'd4,   // slave acknowledge slot
      ST_RDATA = 3'd5,   // shifting out read byte
      ST_RACK  = 3'd6    // host acknowledge slot
   } eng_state_t;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/dpot_line_filter.sv
module dpot_line_filter #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);

   logic s1_q, s2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= 1'b1;
         s2_q <= 1'b1;
      end else begin
         s1_q <= raw_i;
         s2_q <= s1_q;
      end
   end

   generate
      if (FILT_LEN == 0) begin : g_bypass
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b1;
            else        q <= s2_q;
         end
         assign clean_o = q;
      end else begin : g_count
         localparam int CNT_W = $clog2(FILT_LEN + 1);
         logic [CNT_W-1:0] cnt_q;
         logic             q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q     <= 1'b1;
               cnt_q <= '0;
            end else if (s2_q != q) begin
               if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
                  q     <= s2_q;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else begin
               cnt_q <= '0;
            end
         end
         assign clean_o = q;
      end
   endgenerate

endmodule

// File: rtl/dpot_bus_cond.sv
module dpot_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);

   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_i;
         sda_d <= sda_i;
      end
   end

   assign start_o    = scl_i & scl_d & sda_d & ~sda_i;
   assign stop_o     = scl_i & scl_d & ~sda_d & sda_i;
   assign scl_rise_o = scl_i & ~scl_d;
   assign scl_fall_o = ~scl_i & scl_d;

endmodule

// File: rtl/dpot_wiper_bank.sv
module dpot_wiper_bank #(
   parameter int                NUM_WIPERS = 4,
   parameter int                WIPER_W    = 8,
   parameter logic [WIPER_W-1:0] RESET_VAL = 8'h80,
   localparam int               PTR_W      = $clog2(NUM_WIPERS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en_i,
   input  logic [PTR_W-1:0]              wr_idx_i,
   input  logic [WIPER_W-1:0]            wr_data_i,
   input  logic [PTR_W-1:0]              rd_idx_i,
   output logic [WIPER_W-1:0]            rd_data_o,
   output logic [NUM_WIPERS*WIPER_W-1:0] flat_o
);

   logic [WIPER_W-1:0] regs_q [NUM_WIPERS];

   generate
      for (genvar k = 0; k < NUM_WIPERS; k++) begin : g_wiper
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs_q[k] <= RESET_VAL;
            else if (wr_en_i && (wr_idx_i == PTR_W'(k)))
               regs_q[k] <= wr_data_i;
         end
         assign flat_o[k*WIPER_W +: WIPER_W] = regs_q[k];
      end
   endgenerate

   assign rd_data_o = regs_q[rd_idx_i];

endmodule

// File: rtl/dpot_i2c_engine.sv
module dpot_i2c_engine
   import dpot_pkg::*;
#(
   parameter int               NUM_WIPERS = 4,
   parameter int               STRAP_W    = 3,
   parameter logic [6-STRAP_W:0] DEV_PREFIX = 4'b0101,
   localparam int              PTR_W      = $clog2(NUM_WIPERS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               scl_rise_i,
   input  logic               scl_fall_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic [BYTE_W-1:0]  rd_data_i,
   output logic [PTR_W-1:0]   ptr_o,
   output logic               wr_en_o,
   output logic [BYTE_W-1:0]  wr_data_o,
   output logic               sda_oe_o,
   output eng_state_t         state_o
);

   eng_state_t         state_q, nxt_q;
   logic [3:0]         bitcnt_q;
   logic [BYTE_W-1:0]  rxsh_q, txsh_q;
   logic [PTR_W-1:0]   ptr_q;
   logic               mack_q;
   logic               id_hit, reg_ok, is_rx;

   assign id_hit = (rxsh_q[7:1] == {DEV_PREFIX, strap_i});
   assign reg_ok = (rxsh_q < BYTE_W'(NUM_WIPERS));
   assign is_rx  = (state_q == ST_ID) || (state_q == ST_REG) || (state_q == ST_WDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         nxt_q     <= ST_IDLE;
         bitcnt_q  <= '0;
         rxsh_q    <= '0;
         txsh_q    <= '0;
         ptr_q     <= '0;
         mack_q    <= 1'b0;
         sda_oe_o  <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_i) begin
            state_q  <= ST_ID;
            bitcnt_q <= '0;
            sda_oe_o <= 1'b0;
         end else if (stop_i) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            sda_oe_o <= 1'b0;
         end else if (is_rx) begin
            if (scl_rise_i && bitcnt_q < 4'd8) begin
               rxsh_q   <= {rxsh_q[BYTE_W-2:0], sda_i};
               bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall_i && bitcnt_q == 4'd8) begin
               bitcnt_q <= '0;
               state_q  <= ST_IDLE;
               unique case (state_q)
                  ST_ID: if (id_hit) begin
                     sda_oe_o <= 1'b1;
                     state_q  <= ST_ACK;
                     nxt_q    <= rxsh_q[0] ? ST_RDATA : ST_REG;
                  end
                  ST_REG: if (reg_ok) begin
                     ptr_q    <= rxsh_q[PTR_W-1:0];
                     sda_oe_o <= 1'b1;
                     state_q  <= ST_ACK;
                     nxt_q    <= ST_WDATA;
                  end
                  default: begin
                     wr_en_o   <= 1'b1;
                     wr_data_o <= rxsh_q;
                     sda_oe_o  <= 1'b1;
                     state_q   <= ST_ACK;
                     nxt_q     <= ST_IDLE;
                  end
               endcase
            end
         end else begin
            unique case (state_q)
               ST_ACK: if (scl_fall_i) begin
                  state_q  <= nxt_q;
                  bitcnt_q <= '0;
                  if (nxt_q == ST_RDATA) begin
                     sda_oe_o <= ~rd_data_i[BYTE_W-1];
                     txsh_q   <= {rd_data_i[BYTE_W-2:0], 1'b0};
                  end else begin
                     sda_oe_o <= 1'b0;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise_i) begin
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end else if (scl_fall_i) begin
                     if (bitcnt_q == 4'd8) begin
                        sda_oe_o <= 1'b0;
                        ptr_q    <= ptr_q + 1'b1;
                        bitcnt_q <= '0;
                        state_q  <= ST_RACK;
                     end else begin
                        sda_oe_o <= ~txsh_q[BYTE_W-1];
                        txsh_q   <= {txsh_q[BYTE_W-2:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise_i) begin
                     mack_q <= ~sda_i;
                  end else if (scl_fall_i) begin
                     if (mack_q) begin
                        sda_oe_o <= ~rd_data_i[BYTE_W-1];
                        txsh_q   <= {rd_data_i[BYTE_W-2:0], 1'b0};
                        state_q  <= ST_RDATA;
                     end else begin
                        sda_oe_o <= 1'b0;
                        state_q  <= ST_IDLE;
                     end
                  end
               end
               default: sda_oe_o <= 1'b0;
            endcase
         end
      end
   end

   assign ptr_o   = ptr_q;
   assign state_o = state_q;

endmodule

// File: rtl/quad_wiper_i2c.sv
module quad_wiper_i2c
   import dpot_pkg::*;
#(
   parameter int                 NUM_WIPERS = 4,
   parameter int                 WIPER_W    = 8,
   parameter int                 STRAP_W    = 3,
   parameter int                 FILT_LEN   = 3,
   parameter logic [6-STRAP_W:0] DEV_PREFIX = 4'b0101,
   parameter logic [WIPER_W-1:0] RESET_VAL  = 8'h80,
   localparam int                PTR_W      = $clog2(NUM_WIPERS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          scl_i,
   input  logic                          sda_i,
   input  logic [STRAP_W-1:0]            strap_i,
   output logic                          sda_oe_o,
   output logic [NUM_WIPERS*WIPER_W-1:0] wiper_o
);

   // elaboration-time parameter checks
   if (WIPER_W != BYTE_W) begin : g_bad_width
      $error("WIPER_W must equal the bus byte width");
   end
   if (NUM_WIPERS < 2 || (1 << PTR_W) != NUM_WIPERS) begin : g_bad_count
      $error("NUM_WIPERS must be a power of two, at least 2");
   end
   if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_strap
      $error("STRAP_W must be 1 to 6");
   end
   if (FILT_LEN < 0) begin : g_bad_filt
      $error("FILT_LEN must not be negative");
   end

   logic [1:0] raw_lines, filt_lines;
   logic       scl_f, sda_f;
   logic       start, stop, scl_rise, scl_fall;
   logic       wr_en;
   logic [PTR_W-1:0]   ptr;
   logic [WIPER_W-1:0] wr_data, rd_data;
   eng_state_t         eng_state;

   assign raw_lines = {sda_i, scl_i};

   generate
      for (genvar l = 0; l < 2; l++) begin : g_line
         dpot_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_lines[l]),
            .clean_o (filt_lines[l])
         );
      end
   endgenerate

   assign scl_f = filt_lines[0];
   assign sda_f = filt_lines[1];

   dpot_bus_cond u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_f),
      .sda_i      (sda_f),
      .start_o    (start),
      .stop_o     (stop),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall)
   );

   dpot_i2c_engine #(
      .NUM_WIPERS (NUM_WIPERS),
      .STRAP_W    (STRAP_W),
      .DEV_PREFIX (DEV_PREFIX)
   ) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .stop_i     (stop),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .sda_i      (sda_f),
      .strap_i    (strap_i),
      .rd_data_i  (rd_data),
      .ptr_o      (ptr),
      .wr_en_o    (wr_en),
      .wr_data_o  (wr_data),
      .sda_oe_o   (sda_oe_o),
      .state_o    (eng_state)
   );

   dpot_wiper_bank #(
      .NUM_WIPERS (NUM_WIPERS),
      .WIPER_W    (WIPER_W),
      .RESET_VAL  (RESET_VAL)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_idx_i  (ptr),
      .wr_data_i (wr_data),
      .rd_idx_i  (ptr),
      .rd_data_o (rd_data),
      .flat_o    (wiper_o)
   );

endmodule

// File: rtl/dpot_wiper_checker.sv
module dpot_wiper_checker
   import dpot_pkg::*;
#(
   parameter int                 NUM_WIPERS = 4,
   parameter int                 WIPER_W    = 8,
   parameter logic [WIPER_W-1:0] RESET_VAL  = 8'h80
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          scl_f,
   input logic                          sda_oe,
   input logic [NUM_WIPERS*WIPER_W-1:0] wipers,
   input eng_state_t                    state
);

   logic [NUM_WIPERS*WIPER_W-1:0] prev_q;
   logic [NUM_WIPERS-1:0]         chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= {NUM_WIPERS{RESET_VAL}};
      else        prev_q <= wipers;
   end

   for (genvar k = 0; k < NUM_WIPERS; k++) begin : g_chg
      assign chg[k] = (wipers[k*WIPER_W +: WIPER_W] != prev_q[k*WIPER_W +: WIPER_W]);
   end

   // R1: reset loads mid-scale and releases the data line
   a_r1_reset_mid: assert property (@(posedge clk)
      !rst_n |=> (wipers == {NUM_WIPERS{RESET_VAL}}) && !sda_oe);

   // R3: idle engine never pulls the line
   a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R5: no more than one wiper moves per cycle
   a_r5_one_wiper: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chg));

   // R9: drive enable moves only with SCL low
   a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_f);

   // R9: wiper outputs move only with SCL low
   a_r9_wiper_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wipers) |-> !scl_f);

endmodule

bind quad_wiper_i2c dpot_wiper_checker #(
   .NUM_WIPERS (NUM_WIPERS),
   .WIPER_W    (WIPER_W),
   .RESET_VAL  (RESET_VAL)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .scl_f  (scl_f),
   .sda_oe (sda_oe_o),
   .wipers (wiper_o),
   .state  (eng_state)
);

// File: tb/sim_quad_wiper_i2c.sv
`timescale 1ns/1ps
module sim_quad_wiper_i2c;

   localparam int Q = 16;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] ID_W  = {4'b0101, STRAP, 1'b0};
   localparam logic [7:0] ID_R  = {4'b0101, STRAP, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic [31:0] wiper;
   logic sda_line;

   int n_chk = 0;
   int n_fail = 0;
   int viol = 0;
   int hi_cnt = 0;
   bit done = 0;
   logic oe_prev = 1'b0;
   logic [7:0] model [4];

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   quad_wiper_i2c u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .strap_i  (STRAP),
      .sda_oe_o (sda_oe),
      .wiper_o  (wiper)
   );

   // drive-while-SCL-high monitor (R9)
   always @(negedge clk) begin
      if (scl_m) hi_cnt <= hi_cnt + 1; else hi_cnt <= 0;
      if (rst_n && hi_cnt >= 10 && sda_oe != oe_prev) viol <= viol + 1;
      oe_prev <= sda_oe;
   end

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_wipers(input string req);
      for (int k = 0; k < 4; k++)
         chk(wiper[k*8 +: 8] == model[k], req, wiper[k*8 +: 8], model[k]);
   endtask

   task automatic bit_cyc(input logic b, input bit g, output logic s);
      sda_m = b;
      wq(Q);
      if (g) begin
         scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(4);
      end
      scl_m = 1'b1;
      wq(Q);
      s = sda_line;
      if (g) begin
         sda_m = ~b; wq(2); sda_m = b;
      end
      wq(Q);
      scl_m = 1'b0;
      wq(Q);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b1; wq(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] d, input bit g, output bit ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_cyc(d[i], g, s);
      bit_cyc(1'b1, g, s);
      ack = !s;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_cyc(1'b1, 1'b0, s);
         d[i] = s;
      end
      bit_cyc(!mack, 1'b0, s);
   endtask

   task automatic write_txn(input logic [7:0] a, input logic [7:0] v, input bit g,
                            output bit k1, output bit k2, output bit k3);
      bus_start();
      send_byte(ID_W, g, k1);
      send_byte(a, g, k2);
      send_byte(v, g, k3);
      bus_stop();
   endtask

   initial begin
      bit k1, k2, k3;
      logic [7:0] d, v;
      logic s;
      for (int k = 0; k < 4; k++) model[k] = 8'h80;

      wq(3);
      chk(sda_oe == 1'b0, "R1 drive in reset", sda_oe, 0);
      chk_wipers("R1 reset value");
      wq(2);
      rst_n = 1'b1;
      wq(20);
      chk_wipers("R1 after reset");
      chk(sda_oe == 1'b0, "R1 released", sda_oe, 0);

      // R11: clocked bytes with no START
      send_byte(ID_W, 1'b0, k1);
      send_byte(8'h01, 1'b0, k2);
      send_byte(8'h33, 1'b0, k3);
      chk(!k1 && !k2 && !k3, "R11 no ack before START", {k1, k2, k3}, 0);
      chk_wipers("R11 wipers untouched");

      // R2 R5: write sweep over every wiper and pattern
      for (int p = 0; p < 4; p++) begin
         for (int r = 0; r < 4; r++) begin
            case (p)
               0: v = 8'h00;
               1: v = 8'hFF;
               2: v = 8'hA5 ^ 8'(r);
               default: v = 8'h5A + 8'(r * 8'h13);
            endcase
            write_txn(8'(r), v, 1'b0, k1, k2, k3);
            model[r] = v;
            chk(k1, "R2 id ack", k1, 1);
            chk(k2 && k3, "R5 addr/data ack", {k2, k3}, 3);
            chk_wipers("R5 write stored");
         end
      end

      // R6: reads from every start index with wrap
      for (int p = 0; p < 4; p++) begin
         bus_start();
         send_byte(ID_W, 1'b0, k1);
         send_byte(8'(p), 1'b0, k2);
         bus_start();
         send_byte(ID_R, 1'b0, k3);
         chk(k1 && k2 && k3, "R6 read header ack", {k1, k2, k3}, 7);
         for (int j = 0; j < 6; j++) begin
            recv_byte(j != 5, d);
            chk(d == model[(p + j) % 4], "R6 read data", d, model[(p + j) % 4]);
         end
         // R7: after host NACK the slave drives nothing
         bit_cyc(1'b1, 1'b0, s);
         chk(s == 1'b1 && sda_oe == 1'b0, "R7 released after nack", s, 1);
         bus_stop();
      end

      // R3: near-miss identification bytes
      for (int b = 1; b < 8; b++) begin
         bus_start();
         send_byte(ID_W ^ (8'h1 << b), 1'b0, k1);
         send_byte(8'h00, 1'b0, k2);
         send_byte(8'h77, 1'b0, k3);
         bus_stop();
         chk(!k1 && !k2 && !k3, "R3 mismatch nack", {k1, k2, k3}, 0);
      end
      chk_wipers("R3 wipers untouched");

      // R4: out-of-range address bytes
      write_txn(8'h04, 8'h11, 1'b0, k1, k2, k3);
      chk(k1 && !k2 && !k3, "R4 addr 04h nack", {k1, k2, k3}, 4);
      write_txn(8'hFF, 8'h22, 1'b0, k1, k2, k3);
      chk(k1 && !k2 && !k3, "R4 addr FFh nack", {k1, k2, k3}, 4);
      chk_wipers("R4 wipers untouched");

      // R5: second data byte refused
      bus_start();
      send_byte(ID_W, 1'b0, k1);
      send_byte(8'h02, 1'b0, k2);
      send_byte(8'h3C, 1'b0, k3);
      model[2] = 8'h3C;
      send_byte(8'hC3, 1'b0, k1);
      bus_stop();
      chk(k3 && !k1, "R5 extra byte nack", {k3, k1}, 2);
      chk_wipers("R5 single byte stored");

      // R8: STOP in the middle of a data byte
      bus_start();
      send_byte(ID_W, 1'b0, k1);
      send_byte(8'h01, 1'b0, k2);
      for (int i = 0; i < 4; i++) bit_cyc(1'b0, 1'b0, s);
      bus_stop();
      chk_wipers("R8 stop mid-byte");
      // R8: START in the middle, then a good write
      bus_start();
      send_byte(ID_W, 1'b0, k1);
      send_byte(8'h03, 1'b0, k2);
      for (int i = 0; i < 3; i++) bit_cyc(1'b1, 1'b0, s);
      bus_start();
      send_byte(ID_W, 1'b0, k1);
      send_byte(8'h00, 1'b0, k2);
      send_byte(8'h96, 1'b0, k3);
      bus_stop();
      model[0] = 8'h96;
      chk(k1 && k2 && k3, "R8 restart acks", {k1, k2, k3}, 7);
      chk_wipers("R8 start mid-byte");

      // R10: short glitches on both lines on every bit
      write_txn(8'h01, 8'h6B, 1'b1, k1, k2, k3);
      model[1] = 8'h6B;
      chk(k1 && k2 && k3, "R10 glitch acks", {k1, k2, k3}, 7);
      chk_wipers("R10 glitch write");

      chk(viol == 0, "R9 drive changed with SCL high", viol, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule